// File: doc/BRIEF.md
# Sticky Alarm Interrupt Controller

This block gathers four clock-path alarm conditions (PLL loss-of-lock, holdover entry, and loss-of-signal on two reference inputs) and latches each into a sticky status flag. A flag can be cleared by software only once its alarm has gone away. Each flag has its own enable. While any enabled flag is set, a device-level interrupt status is raised and an active-low open-drain interrupt pin is pulled low.

The raw alarm inputs arrive from other clock domains. They are passed through a multi-stage synchronizer onto the register clock. The loss-of-lock alarm is formed from a lock indication and an internal synchronization-complete indication. A mode bit selects whether lock alone releases the alarm, or whether lock together with settled internal synchronization is needed.

A small register port gives access to status, enable, control and live alarm state. A write-protect input locks the configuration registers but leaves status clearing working.

Top module: `sai_alarm_irq`

## Requirements
- R1: After reset, all status flags, all enable bits and the release-mode bit are 0; dev_irq is 0, irq_oe is 0 and irq_n is 1.
- R2: An alarm that is active at the synchronizer output sets its flag. With SYNC_STAGES=2, a change on a raw alarm input is reflected in the flag after the third rising clock edge. Bit positions in status, enable and live registers are: bit0 loss-of-lock, bit1 holdover, bit2 loss-of-signal 0, bit3 loss-of-signal 1.
- R3: A flag stays set after its alarm goes inactive until a write to the status register (address 0) has a 1 in that flag's bit position.
- R4: A write-1 clear to a flag whose synchronized alarm is still active is ignored, and the flag stays set. A set and a clear in the same cycle resolve to set.
- R5: The loss-of-lock alarm is active when pll_lock is 0. When control bit 0 (address 2) is 1, it is also active while sync_done is 0.
- R6: dev_irq is 1 exactly when some flag and its enable bit (address 1) are both 1. irq_oe equals dev_irq, and irq_n is its inverse.
- R7: While wp is 1, writes to the enable and control registers have no effect, but write-1 clears to the status register still take effect.
- R8: A read registers its data on the clock edge where rd_en is high. Address 0 returns the flags, address 1 the enables, address 2 the mode bit in bit 0, and address 3 the live synchronized alarms. All unused upper bits read 0.
- R9: Writing 0 to a status bit leaves that flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_lock | input | 1 | PLL lock indication, 1 = locked (asynchronous) |
| sync_done | input | 1 | Internal synchronization settled, 1 = done (asynchronous) |
| hold_alarm | input | 1 | Holdover alarm (asynchronous) |
| los_alarm | input | 2 | Loss-of-signal alarms for the two inputs (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wp | input | 1 | Write protect, 1 = configuration writes ignored |
| rdata | output | 8 | Read data, registered |
| dev_irq | output | 1 | Device interrupt status |
| irq_oe | output | 1 | Open-drain enable: 1 drives the interrupt pin low |
| irq_n | output | 1 | Interrupt pin level as seen by the block, active low |

## Verification
The bench builds the block with its defaults: four sources, two synchronizer stages and an 8-bit data path. With four sources, the bench can sweep every combination of 16 latched flag patterns against 16 enable masks, which covers the whole interrupt combining function. With two synchronizer stages, the latency from an input change to a flag change is a fixed three edges that the bench can count. The bench also forces clear attempts against active alarms, tries both release modes with lock present and synchronization pending, and writes under write protect.

// File: rtl/sai_pkg.sv
package sai_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_LOL  = 0;
  localparam int SRC_HOLD = 1;
  localparam int SRC_LOS0 = 2;
  localparam int SRC_LOS1 = 3;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_ENABLE = 2'd1,
    A_CTRL   = 2'd2,
    A_LIVE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sai_sync.sv
module sai_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sai_lol_qual.sv
module sai_lol_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_s,
  input  logic sync_pend_s,
  input  logic strict_mode,
  output logic lol_alarm
);
  // In strict mode, release also waits for internal synchronization to settle.
  always_comb lol_alarm = unlock_s | (strict_mode & sync_pend_s);

  p_strict_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_mode && sync_pend_s) |-> lol_alarm);
  p_lock_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strict_mode && !unlock_s) |-> !lol_alarm);
endmodule

// File: rtl/sai_flags.sv
module sai_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alarm,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag[i] <= 1'b0;
      else if (alarm[i]) flag[i] <= 1'b1;   // set wins over clear
      else if (clr[i])   flag[i] <= 1'b0;
    end

    p_set_on_alarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alarm[i] |=> flag[i]);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
    p_clear_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && alarm[i] && clr[i]) |=> flag[i]);
  end
endmodule

// File: rtl/sai_regs.sv
module sai_regs
  import sai_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp,
  input  logic [N-1:0]      flag,
  input  logic [N-1:0]      live,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      en,
  output logic              strict_mode,
  output logic [N-1:0]      clr
);
  localparam int PADN = DATA_W - N;
  localparam int PADM = DATA_W - 1;

  reg_addr_e   a;
  logic        cfg_wr;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    a      = reg_addr_e'(addr);
    cfg_wr = wr_en && !wp;
    clr    = (wr_en && a == A_STATUS) ? wdata[N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en          <= '0;
      strict_mode <= 1'b0;
    end else if (cfg_wr) begin
      if (a == A_ENABLE) en          <= wdata[N-1:0];
      if (a == A_CTRL)   strict_mode <= wdata[0];
    end
  end

  always_comb begin
    unique case (a)
      A_STATUS: rd_mux = {{PADN{1'b0}}, flag};
      A_ENABLE: rd_mux = {{PADN{1'b0}}, en};
      A_CTRL:   rd_mux = {{PADM{1'b0}}, strict_mode};
      default:  rd_mux = {{PADN{1'b0}}, live};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_wp_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp) |=> ($stable(en) && $stable(strict_mode)));
endmodule

// File: rtl/sai_alarm_irq.sv
module sai_alarm_irq
  import sai_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_lock,
  input  logic              sync_done,
  input  logic              hold_alarm,
  input  logic [1:0]        los_alarm,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp,
  output logic [DATA_W-1:0] rdata,
  output logic              dev_irq,
  output logic              irq_oe,
  output logic              irq_n
);
  localparam int RAW_W = NSRC + 1;

  logic [RAW_W-1:0] raw, raw_s;
  logic [NSRC-1:0]  live, flag, en, clr;
  logic             strict_mode, lol_alarm;

  // Inputs are carried in alarm polarity so the synchronizer resets to "quiet".
  assign raw = {los_alarm[1], los_alarm[0], hold_alarm, ~sync_done, ~pll_lock};

  sai_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(raw_s)
  );

  sai_lol_qual u_lol (
    .clk(clk), .rst_n(rst_n), .unlock_s(raw_s[0]), .sync_pend_s(raw_s[1]),
    .strict_mode(strict_mode), .lol_alarm(lol_alarm)
  );

  always_comb begin
    live           = '0;
    live[SRC_LOL]  = lol_alarm;
    live[SRC_HOLD] = raw_s[2];
    live[SRC_LOS0] = raw_s[3];
    live[SRC_LOS1] = raw_s[4];
  end

  sai_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .alarm(live), .clr(clr), .flag(flag)
  );

  sai_regs #(.N(NSRC), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .wp(wp), .flag(flag), .live(live), .rdata(rdata),
    .en(en), .strict_mode(strict_mode), .clr(clr)
  );

  always_comb begin
    dev_irq = |(flag & en);
    irq_oe  = dev_irq;
    irq_n   = ~irq_oe;
  end

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !dev_irq);
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag == '0) |-> (irq_n && !irq_oe));
endmodule

// File: tb/tb_sai_alarm_irq.sv
module tb_sai_alarm_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_lock = 1'b1, sync_done = 1'b1, hold_alarm = 1'b0;
  logic [1:0] los_alarm = 2'b00;
  logic       wr_en = 1'b0, rd_en = 1'b0, wp = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       dev_irq, irq_oe, irq_n;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sai_alarm_irq dut (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .sync_done(sync_done),
    .hold_alarm(hold_alarm), .los_alarm(los_alarm), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .wp(wp), .rdata(rdata),
    .dev_irq(dev_irq), .irq_oe(irq_oe), .irq_n(irq_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    step(1);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Drive alarm pattern: bit0 LOL (via lock), bit1 hold, bit2 los0, bit3 los1.
  task automatic drive(input logic [3:0] p);
    pll_lock = ~p[0]; hold_alarm = p[1]; los_alarm = p[3:2];
  endtask

  initial begin
    logic [7:0] v;
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(2'd0, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 enable", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 mode", v, 0);
    chk(!dev_irq && !irq_oe && irq_n, "R1 irq", {dev_irq, irq_oe, irq_n}, 1);

    // R2 latency: flag appears after the third edge
    drive(4'b0100);
    step(2);
    rd(2'd0, v); chk(v == 8'h00, "R2 not before 3 edges", v, 0);
    rd(2'd0, v); chk(v == 8'h04, "R2 set", v, 4);
    rd(2'd3, v); chk(v == 8'h04, "R8 live", v, 4);

    // R4 clear blocked while alarm active
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk(v == 8'h04, "R4 clear ignored", v, 4);
    // R3 sticky after alarm goes away
    drive(4'b0000);
    step(4);
    rd(2'd0, v); chk(v == 8'h04, "R3 sticky", v, 4);
    // R9 write zero no effect
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk(v == 8'h04, "R9 zero write", v, 4);
    wr(2'd0, 8'h04);
    rd(2'd0, v); chk(v == 8'h00, "R3 cleared", v, 0);

    // R5 mode 0: lock present, sync pending -> no LOL
    sync_done = 1'b0;
    step(4);
    rd(2'd0, v); chk(v == 8'h00, "R5 mode0", v, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk(v == 8'h01, "R8 mode read", v, 1);
    step(1);
    rd(2'd0, v); chk(v == 8'h01, "R5 mode1 lol", v, 1);
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk(v == 8'h01, "R5 held while pending", v, 1);
    sync_done = 1'b1;
    step(4);
    wr(2'd0, 8'h01);
    rd(2'd0, v); chk(v == 8'h00, "R5 released", v, 0);

    // R7 write protect
    wp = 1'b1;
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h00);
    rd(2'd1, v); chk(v == 8'h00, "R7 enable locked", v, 0);
    rd(2'd2, v); chk(v == 8'h01, "R7 mode locked", v, 1);
    drive(4'b0010); step(4); drive(4'b0000); step(4);
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk(v == 8'h00, "R7 clear under wp", v, 0);
    wp = 1'b0;
    wr(2'd2, 8'h00);

    // R6 sweep: every flag pattern against every enable mask
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        drive(4'(p)); step(4); drive(4'b0000); step(4);
        wr(2'd1, 8'(e));
        chk(dev_irq == |(p & e) && irq_oe == dev_irq && irq_n == !dev_irq,
            "R6 irq", {dev_irq, irq_oe, irq_n}, (|(p & e)) ? 6 : 1);
        wr(2'd0, 8'h0F);
        chk(!dev_irq && irq_n, "R6 cleared", {dev_irq, irq_n}, 1);
      end
    end

    // R4 set and clear in the same cycle: set wins
    wr(2'd1, 8'h00);
    drive(4'b1000);
    step(2);
    wr(2'd0, 8'h08);
    drive(4'b0000);
    rd(2'd0, v); chk(v == 8'h08, "R4 set wins", v, 8);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule